// File: doc/BRIEF.md
# Character-Mapped Monochrome Text Generator

This block turns a flat buffer of character codes into a monochrome raster with one composite sync line and one video line. It walks a 24-row text screen, cell by cell. For each 8×8 cell it reads one code from an external buffer through a read port, fetches the glyph row for the current scan line and shifts the pixels out one per clock. The screen is 32 or 64 columns wide, and a mode input picks the width. The buffer is linear in both modes, so the same offset lands on a different screen position when the width changes.

Glyph pixels come from a built-in computed font by default. An I/O-style write sets a select bit that switches the lookup to a user-writable glyph RAM. The RAM has its own write port and can be loaded at any time. Any code with its top bit set is drawn in inverse video. Blanking and sync intervals come from the pixel and line counters, and their lengths are parameters.

Top module: `char_display_gen`

## Requirements
- R1: While `rst_n` is low, and for the first three clocks after it rises, `sync_out` and `video_out` are 0. The counters restart at pixel 0 of line 0 in 32-column mode.
- R2: On the first pixel clock of every visible cell, `buf_rd_addr` equals row × columns + column, where row = line / 8, column = pixel / 8 and columns is 32 or 64. There is no remapping between modes: offset 0x020 is row 1, column 0 in 32-column mode and row 0, column 32 in 64-column mode.
- R3: A line is active width + `H_FRONT` + `H_SYNC` + `H_BACK` clocks long, with an active width of 256 or 512. A frame is 192 + `V_FRONT` + `V_SYNC` + `V_BACK` lines. `sync_out` is high during the `H_SYNC` clocks that follow the front porch of each line, and for every clock of the `V_SYNC` lines. Video and sync for a counter position appear three clocks after that position.
- R4: A code of 0x80 or above is drawn with every pixel of its glyph row inverted. The glyph lookup uses the low 7 bits of the code.
- R5: Fixed font, MSB drawn leftmost. Codes 0x30–0x39 and 0x41–0x5A use glyph row 0x00 on rows 0 and 7, {1, c[5:0], 1} on odd rows and {1, ~c[5:0], 1} on rows 2, 4 and 6. Every other code is blank.
- R6: A write with `io_wr` high loads `io_font_sel` into the select bit. When the bit is 1, the glyph row is the user RAM word at address {code[6:0], row[2:0]}, MSB leftmost.
- R7: `video_out` is 0 whenever the position is outside the 256/512 × 192 active area.
- R8: A change on `mode_wide` takes effect only at the frame boundary that follows it. The frame in progress keeps its width.
- R9: Writes to the glyph RAM while the fixed font is selected do not change `video_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wide | input | 1 | Requested width: 1 = 64 columns, 0 = 32 columns |
| io_wr | input | 1 | Strobe that loads the font select bit |
| io_font_sel | input | 1 | Font select value: 1 = user glyph RAM |
| glyph_we | input | 1 | Glyph RAM write enable |
| glyph_waddr | input | GA (10) | Glyph RAM address {code[6:0], row[2:0]} |
| glyph_wdata | input | 8 | Glyph row pixels, MSB leftmost |
| buf_rd_addr | output | AW (11) | Character buffer read address |
| buf_rd_data | input | 8 | Character code, valid one clock after its address |
| sync_out | output | 1 | Composite sync, active high |
| video_out | output | 1 | Monochrome pixel |

## Verification
The fetch address depends only on the counters, so it is compared in the same cycle the counter reaches a cell's first pixel. Video and sync for a position are due three clocks later: one for the buffer read, one for the glyph lookup and one for the shift register. The bench therefore holds a four-deep history of expected values and compares each output against the entry from three steps back, sampling at the falling edge. The font select and the mode request are changed only during vertical blanking or mid-frame respectively, which tests the frame-boundary rule for the mode. The glyph RAM is loaded while the fixed font is on screen.

// File: rtl/cgd_pkg.sv
package cgd_pkg;
   localparam int CODE_BITS = 7;

   typedef logic [7:0] glyph_row_t;

   typedef struct packed {
      logic       load;
      logic       active;
      logic       sync;
      logic [2:0] grow;
   } fetch_stage_t;

   // Computed stroke font: digits and upper-case letters, blank elsewhere.
   function automatic glyph_row_t fixed_glyph(input logic [CODE_BITS-1:0] c,
                                              input logic [2:0] r);
      logic known;
      known = ((c >= 7'h30) && (c <= 7'h39)) || ((c >= 7'h41) && (c <= 7'h5A));
      if (!known || (r == 3'd0) || (r == 3'd7)) return 8'h00;
      if (r[0]) return {1'b1, c[5:0], 1'b1};
      return {1'b1, ~c[5:0], 1'b1};
   endfunction
endpackage

// File: rtl/cgd_timing.sv
module cgd_timing #(
   parameter int COLS_NARROW = 32,
   parameter int COLS_WIDE   = 64,
   parameter int TEXT_ROWS   = 24,
   parameter int GLYPH_W     = 8,
   parameter int GLYPH_H     = 8,
   parameter int H_FRONT     = 16,
   parameter int H_SYNC      = 48,
   parameter int H_BACK      = 48,
   parameter int V_FRONT     = 4,
   parameter int V_SYNC      = 4,
   parameter int V_BACK      = 20,
   parameter int HW          = 10,
   parameter int VW          = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mode_req,
   output logic          wide,
   output logic [HW-1:0] hpos,
   output logic [VW-1:0] vpos,
   output logic          active,
   output logic          sync,
   output logic          cell_start
);
   localparam int HA_N   = COLS_NARROW * GLYPH_W;
   localparam int HA_W   = COLS_WIDE * GLYPH_W;
   localparam int HT_N   = HA_N + H_FRONT + H_SYNC + H_BACK;
   localparam int HT_W   = HA_W + H_FRONT + H_SYNC + H_BACK;
   localparam int VA     = TEXT_ROWS * GLYPH_H;
   localparam int VT     = VA + V_FRONT + V_SYNC + V_BACK;
   localparam int LOG_GW = $clog2(GLYPH_W);

   logic [HW-1:0] h_act, h_last;
   logic line_end, frame_end, hs, vs;

   always_comb begin
      h_act      = wide ? HW'(HA_W) : HW'(HA_N);
      h_last     = wide ? HW'(HT_W - 1) : HW'(HT_N - 1);
      line_end   = (hpos == h_last);
      frame_end  = line_end && (vpos == VW'(VT - 1));
      hs         = (hpos >= h_act + HW'(H_FRONT)) && (hpos < h_act + HW'(H_FRONT + H_SYNC));
      vs         = (vpos >= VW'(VA + V_FRONT)) && (vpos < VW'(VA + V_FRONT + V_SYNC));
      active     = (hpos < h_act) && (vpos < VW'(VA));
      sync       = hs | vs;
      cell_start = active && (hpos[LOG_GW-1:0] == '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hpos <= '0;
         vpos <= '0;
         wide <= 1'b0;
      end else begin
         hpos <= line_end ? '0 : hpos + 1'b1;
         if (line_end) vpos <= frame_end ? '0 : vpos + 1'b1;
         if (frame_end) wide <= mode_req;
      end
   end

   assert_mode_at_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(wide) |-> $past(frame_end));

   assert_sync_outside_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sync |-> !active);
endmodule

// File: rtl/cgd_glyph.sv
module cgd_glyph
   import cgd_pkg::*;
#(
   parameter bit USER_GLYPHS = 1'b1,
   parameter int GA          = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [7:0]    code,
   input  logic [2:0]    grow,
   input  logic          io_wr,
   input  logic          io_sel,
   input  logic          ram_we,
   input  logic [GA-1:0] ram_waddr,
   input  logic [7:0]    ram_wdata,
   output glyph_row_t    pix_row
);
   localparam int DEPTH = 1 << GA;

   logic       use_ram, sel_q, inv_q;
   glyph_row_t rom_q, ram_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         use_ram <= 1'b0;
         sel_q   <= 1'b0;
      end else begin
         if (io_wr) use_ram <= io_sel;
         sel_q <= use_ram;
      end
   end

   always_ff @(posedge clk) begin
      rom_q <= fixed_glyph(code[CODE_BITS-1:0], grow);
      inv_q <= code[7];
   end

   generate
      if (USER_GLYPHS) begin : g_user_ram
         glyph_row_t mem [0:DEPTH-1];
         always_ff @(posedge clk) begin
            if (ram_we) mem[ram_waddr] <= ram_wdata;
            ram_q <= mem[{code[CODE_BITS-1:0], grow}];
         end
      end else begin : g_fixed_only
         assign ram_q = 8'h00;
      end
   endgenerate

   assign pix_row = (sel_q ? ram_q : rom_q) ^ {8{inv_q}};

   assert_select_by_io_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(use_ram) |-> $past(io_wr));
endmodule

// File: rtl/cgd_serializer.sv
module cgd_serializer
   import cgd_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic       active_in,
   input  logic       sync_in,
   input  glyph_row_t pix_row,
   output logic       video_out,
   output logic       sync_out
);
   glyph_row_t shreg;
   logic       act_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg    <= '0;
         act_q    <= 1'b0;
         sync_out <= 1'b0;
      end else begin
         shreg    <= load ? pix_row : {shreg[6:0], 1'b0};
         act_q    <= active_in;
         sync_out <= sync_in;
      end
   end

   assign video_out = act_q & shreg[7];

   assert_sync_dark_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sync_out |-> !video_out);
endmodule

// File: rtl/char_display_gen.sv
module char_display_gen
   import cgd_pkg::*;
#(
   parameter int COLS_NARROW = 32,
   parameter int COLS_WIDE   = 64,
   parameter int TEXT_ROWS   = 24,
   parameter int GLYPH_W     = 8,
   parameter int GLYPH_H     = 8,
   parameter int H_FRONT     = 16,
   parameter int H_SYNC      = 48,
   parameter int H_BACK      = 48,
   parameter int V_FRONT     = 4,
   parameter int V_SYNC      = 4,
   parameter int V_BACK      = 20,
   parameter bit USER_GLYPHS = 1'b1,
   localparam int HT_W   = COLS_WIDE * GLYPH_W + H_FRONT + H_SYNC + H_BACK,
   localparam int VT     = TEXT_ROWS * GLYPH_H + V_FRONT + V_SYNC + V_BACK,
   localparam int HW     = $clog2(HT_W),
   localparam int VW     = $clog2(VT),
   localparam int AW     = $clog2(TEXT_ROWS * COLS_WIDE),
   localparam int GA     = CODE_BITS + $clog2(GLYPH_H)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mode_wide,
   input  logic          io_wr,
   input  logic          io_font_sel,
   input  logic          glyph_we,
   input  logic [GA-1:0] glyph_waddr,
   input  logic [7:0]    glyph_wdata,
   output logic [AW-1:0] buf_rd_addr,
   input  logic [7:0]    buf_rd_data,
   output logic          sync_out,
   output logic          video_out
);
   localparam int LOG_GW = $clog2(GLYPH_W);
   localparam int LOG_GH = $clog2(GLYPH_H);

   initial begin
      assert (GLYPH_W == 8 && GLYPH_H == 8) else $error("glyph cell must be 8x8");
      assert (COLS_WIDE > COLS_NARROW) else $error("wide mode needs more columns");
      assert (H_SYNC > 0 && V_SYNC > 0) else $error("sync intervals must be non-empty");
   end

   logic          wide, active, sync, cell_start;
   logic [HW-1:0] hpos;
   logic [VW-1:0] vpos;
   logic [AW-1:0] row_ix, col_ix;
   fetch_stage_t  s1;
   logic          s2_load, s2_active, s2_sync;
   glyph_row_t    pix_row;

   cgd_timing #(
      .COLS_NARROW(COLS_NARROW), .COLS_WIDE(COLS_WIDE), .TEXT_ROWS(TEXT_ROWS),
      .GLYPH_W(GLYPH_W), .GLYPH_H(GLYPH_H),
      .H_FRONT(H_FRONT), .H_SYNC(H_SYNC), .H_BACK(H_BACK),
      .V_FRONT(V_FRONT), .V_SYNC(V_SYNC), .V_BACK(V_BACK),
      .HW(HW), .VW(VW)
   ) u_timing (
      .clk(clk), .rst_n(rst_n), .mode_req(mode_wide), .wide(wide),
      .hpos(hpos), .vpos(vpos), .active(active), .sync(sync), .cell_start(cell_start)
   );

   always_comb begin
      row_ix      = AW'(vpos >> LOG_GH);
      col_ix      = AW'(hpos >> LOG_GW);
      buf_rd_addr = row_ix * (wide ? AW'(COLS_WIDE) : AW'(COLS_NARROW)) + col_ix;
   end

   // Stage 1 waits for the buffer read; stage 2 waits for the glyph lookup.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1        <= '0;
         s2_load   <= 1'b0;
         s2_active <= 1'b0;
         s2_sync   <= 1'b0;
      end else begin
         s1        <= '{load: cell_start, active: active, sync: sync, grow: vpos[2:0]};
         s2_load   <= s1.load;
         s2_active <= s1.active;
         s2_sync   <= s1.sync;
      end
   end

   cgd_glyph #(.USER_GLYPHS(USER_GLYPHS), .GA(GA)) u_glyph (
      .clk(clk), .rst_n(rst_n), .code(buf_rd_data), .grow(s1.grow),
      .io_wr(io_wr), .io_sel(io_font_sel),
      .ram_we(glyph_we), .ram_waddr(glyph_waddr), .ram_wdata(glyph_wdata),
      .pix_row(pix_row)
   );

   cgd_serializer u_ser (
      .clk(clk), .rst_n(rst_n), .load(s2_load), .active_in(s2_active),
      .sync_in(s2_sync), .pix_row(pix_row), .video_out(video_out), .sync_out(sync_out)
   );

   assert_fetch_in_buffer_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cell_start |-> (buf_rd_addr < AW'(TEXT_ROWS * COLS_WIDE)));
endmodule

// File: tb/char_display_gen_test.sv
module char_display_gen_test;
   localparam int HF = 4, HS = 4, HB = 4, VF = 2, VS = 2, VB = 2;
   localparam int VA = 192;
   localparam int VT = VA + VF + VS + VB;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic       rst_n = 1'b0, mode_wide = 1'b0, io_wr = 1'b0, io_font_sel = 1'b0;
   logic       glyph_we = 1'b0;
   logic [9:0] glyph_waddr = '0;
   logic [7:0] glyph_wdata = '0;
   logic [10:0] buf_rd_addr;
   logic [7:0]  buf_rd_data;
   logic        sync_out, video_out;

   logic [7:0] mem  [0:2047];
   logic [7:0] uram [0:1023];

   always @(posedge clk) buf_rd_data <= mem[buf_rd_addr];

   char_display_gen #(
      .H_FRONT(HF), .H_SYNC(HS), .H_BACK(HB), .V_FRONT(VF), .V_SYNC(VS), .V_BACK(VB)
   ) uut (
      .clk(clk), .rst_n(rst_n), .mode_wide(mode_wide), .io_wr(io_wr),
      .io_font_sel(io_font_sel), .glyph_we(glyph_we), .glyph_waddr(glyph_waddr),
      .glyph_wdata(glyph_wdata), .buf_rd_addr(buf_rd_addr), .buf_rd_data(buf_rd_data),
      .sync_out(sync_out), .video_out(video_out)
   );

   int    checks = 0, fails = 0;
   bit    done = 0;
   int    mh = 0, mv = 0;
   bit    mwide = 0, psel = 0;
   bit    ev [0:3];
   bit    es [0:3];
   string et [0:3];

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] font_row(input logic [6:0] c, input int r);
      logic [7:0] p;
      bit known;
      known = (c >= 7'h30 && c <= 7'h39) || (c >= 7'h41 && c <= 7'h5A);
      if (!known || r == 0 || r == 7) p = 8'h00;
      else if (r % 2 == 1) p = {1'b1, c[5:0], 1'b1};
      else p = {1'b1, ~c[5:0], 1'b1};
      return p;
   endfunction

   function automatic int line_len(input bit w);
      return (w ? 512 : 256) + HF + HS + HB;
   endfunction

   task automatic expect_at(input int h, input int v, input bit w,
                            output bit vid, output bit syn, output string tag);
      int ha, cols;
      logic [7:0] code, g;
      ha   = w ? 512 : 256;
      cols = w ? 64 : 32;
      syn  = ((h >= ha + HF) && (h < ha + HF + HS)) || ((v >= VA + VF) && (v < VA + VF + VS));
      if (h < ha && v < VA) begin
         code = mem[(v / 8) * cols + h / 8];
         g    = psel ? uram[{code[6:0], 3'(v % 8)}] : font_row(code[6:0], v % 8);
         vid  = g[7 - (h % 8)] ^ code[7];
         if (code[7]) tag = "R4 inverse video";
         else if (psel) tag = "R6 user glyph pixel";
         else tag = "R5 R9 fixed font pixel";
      end else begin
         vid = 1'b0;
         tag = "R7 blanked video";
      end
   endtask

   task automatic step();
      int cols;
      @(posedge clk);
      if (mh == line_len(mwide) - 1) begin
         mh = 0;
         if (mv == VT - 1) begin
            mv = 0;
            mwide = mode_wide;
         end else mv++;
      end else mh++;
      for (int k = 3; k > 0; k--) begin
         ev[k] = ev[k-1];
         es[k] = es[k-1];
         et[k] = et[k-1];
      end
      expect_at(mh, mv, mwide, ev[0], es[0], et[0]);
      @(negedge clk);
      chk(et[3], int'(video_out), int'(ev[3]));
      chk("R3 R8 sync timing", int'(sync_out), int'(es[3]));
      cols = mwide ? 64 : 32;
      if (mh < cols * 8 && mv < VA && mh % 8 == 0)
         chk("R2 fetch address", int'(buf_rd_addr), (mv / 8) * cols + mh / 8);
   endtask

   initial begin
      for (int i = 0; i < 2048; i++) mem[i] = 8'(i * 37 + 11);
      for (int i = 0; i < 1024; i++) uram[i] = 8'h00;
      mem[32] = 8'h41;   // R2: offset 0x020 in both layouts
      mem[33] = 8'hB5;   // R4: inverted '5'
      mem[0]  = 8'h5A;
      repeat (4) @(negedge clk);
      chk("R1 sync during reset", int'(sync_out), 0);
      chk("R1 video during reset", int'(video_out), 0);
      rst_n = 1'b1;
      expect_at(0, 0, 1'b0, ev[0], es[0], et[0]);
      for (int k = 1; k < 4; k++) begin
         ev[k] = 1'b0;
         es[k] = 1'b0;
         et[k] = "R1 output after reset";
      end
      // R9: load user glyphs while the fixed font is on screen
      for (int i = 0; i < 1024; i++) begin
         glyph_we    = 1'b1;
         glyph_waddr = 10'(i);
         glyph_wdata = 8'(i * 13 + 5);
         uram[i]     = 8'(i * 13 + 5);
         step();
      end
      glyph_we = 1'b0;
      while (mv != 100) step();
      mode_wide = 1'b1;   // R8: request mid-frame
      while (!(mv == VA + 1 && mh == 0)) step();
      io_wr = 1'b1;
      io_font_sel = 1'b1;
      psel = 1'b1;        // R6: switch to user glyphs in blanking
      step();
      io_wr = 1'b0;
      io_font_sel = 1'b0;
      while (!(mv == 0 && mh == 0)) step();
      chk("R8 wide mode after boundary", int'(mwide), 1);
      step();
      while (!(mv == 0 && mh == 0)) step();
      repeat (4) step();
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (195000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL R3 watchdog actual=running expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end
endmodule